// File: doc/BRIEF.md
# Quad-Word Flash Program Sequencer

This block sits between a CPU bus and a flash array. When the program control bit is set, it collects four successive 32-bit bus writes into one 128-bit buffer and then issues a single quad-word program command to the array. It also starts page-erase and mass-erase commands when software pulses the start control.

Before anything reaches the array, every request is checked against the rules for access size, alignment, blank target, write protection and command sequence. A request that breaks a rule is refused, raises a dedicated sticky flag and discards any partly filled buffer. The array side uses a simple handshake: a request level stays high for as long as the block is busy, and the array answers with a one-cycle done pulse after a latency of its own.

Software sees busy, buffer-pending, start, end-of-operation and error flags, and two interrupt lines. All flags are write-1-to-clear.

Top module: `qw_prog_seq`

## Requirements
- R1: After reset all seven flags, busy, buffer-pending, start and the three array requests are 0.
- R2: With the program control set, four accepted word writes to one quad-word issue a program request. Each write's 32-bit data goes to lane addr[3:2] of `arr_qdata`, with lane 0 in bits 31:0, and `arr_qaddr` is addr[19:4]. Buffer-pending rises after the first word and falls when the array reports done.
- R3: A write during a program sequence whose size code is not word (size codes: 0 byte, 1 half-word, 2 word) sets the size-error flag (flag bit 5) and empties the buffer.
- R4: The alignment-error flag (bit 4) is set, and the buffer emptied, when the first word has addr[3:0] other than 0, or when a later word has addr[1:0] other than 0 or lies in a different quad-word.
- R5: On the fourth word, if the target quad-word does not read all ones (`arr_blank` low) and the merged data is not all zeros, the programming-error flag (bit 2) is set and nothing is launched. All-zero data is accepted on a used quad-word.
- R6: Each protection area is the inclusive page range first..last and is inactive when first > last. A page erase or a program whose page (addr[19:13]) falls in an active area sets the protection-error flag (bit 3) and is not launched. A mass erase is refused the same way while any area is active.
- R7: Start with neither or both of page erase and mass erase selected sets the sequence-error flag (bit 6) and launches nothing.
- R8: Busy rises on the clock edge that accepts the fourth word or a start, and falls on the edge that samples the array's done. The start flag rises with an accepted erase and falls together with busy.
- R9: While busy, any bus write or start is ignored and sets the sequence-error flag. The running operation and the buffer are unaffected.
- R10: End-of-operation (bit 0) is set on completion only when its enable is high. `irq_eop` is end-of-operation ANDed with that enable.
- R11: Any error sets the operation-error flag (bit 1) only when the error enable is high. `irq_err` is operation-error ANDed with that enable.
- R12: Writing 1 to a bit of `sts_clear` clears that flag and leaves the others. If a flag is set and cleared in the same cycle, the set wins.
- R13: Bus writes while the program control is clear and the block is idle change no flag and leave the buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_prog | input | 1 | Program sequence selected |
| ctl_page_erase | input | 1 | Page erase selected |
| ctl_mass_erase | input | 1 | Mass erase selected |
| ctl_page | input | 7 | Page to erase |
| ctl_start | input | 1 | One-cycle start pulse for erase |
| ctl_eop_ie | input | 1 | End-of-operation interrupt enable |
| ctl_err_ie | input | 1 | Error interrupt enable |
| bus_wr_valid | input | 1 | Bus write strobe |
| bus_wr_addr | input | 20 | Bus byte address |
| bus_wr_data | input | 32 | Bus write data |
| bus_wr_size | input | 2 | Access size code |
| wp_first | input | 14 | First page of each protection area, area 0 in the low bits |
| wp_last | input | 14 | Last page of each protection area |
| sts_clear | input | 7 | Write-1-to-clear strobes, one per flag |
| sts_flags | output | 7 | Sticky flags: 0 eop, 1 operr, 2 progerr, 3 wrperr, 4 pgaerr, 5 sizerr, 6 pgserr |
| sts_busy | output | 1 | Operation in progress |
| sts_pending | output | 1 | Buffer holds data not yet written |
| sts_start | output | 1 | Start flag of a running erase |
| irq_eop | output | 1 | End-of-operation interrupt |
| irq_err | output | 1 | Error interrupt |
| arr_prog_req | output | 1 | Program quad-word request |
| arr_page_erase_req | output | 1 | Erase page request |
| arr_mass_erase_req | output | 1 | Erase all request |
| arr_qaddr | output | 16 | Target quad-word index |
| arr_qdata | output | 128 | Quad-word to program |
| arr_page | output | 7 | Page to erase |
| arr_blank | input | 1 | Quad-word at arr_qaddr reads all ones |
| arr_done | input | 1 | One-cycle completion pulse |

## Verification
Each flag, busy and buffer-pending result shows on the clock edge that samples the stimulus, so the bench drives on the falling edge and reads back at the next falling edge. Busy then stays high for the array model's latency plus one cycle: one cycle for the model to see the request and one for the block to see done. The bench counts those high samples exactly, and reads end-of-operation, the start flag and buffer-pending one falling edge after busy drops. Refused requests are checked at that same first sample, with busy still low.

// File: rtl/qwp_pkg.sv
// Shared types and flag positions for the quad-word program sequencer.
package qwp_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_EPAGE = 2'd2,
        OP_EALL  = 2'd3
    } op_e;

    localparam int F_EOP     = 0;
    localparam int F_OPERR   = 1;
    localparam int F_PROGERR = 2;
    localparam int F_WRPERR  = 3;
    localparam int F_PGAERR  = 4;
    localparam int F_SIZERR  = 5;
    localparam int F_PGSERR  = 6;
    localparam int N_FLAGS   = 7;

    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int QWORD_W = WORD_W * LANES;
endpackage

// File: rtl/qwp_prot_check.sv
// Protection range check. Compares a program page and an erase page against
// N_AREAS inclusive page ranges. An area whose first page exceeds its last
// page is inactive. Purely combinational; assumes stable inputs per cycle.
module qwp_prot_check #(
    parameter int PW      = 7,
    parameter int N_AREAS = 2
) (
    input  logic [PW-1:0]         page_prog,
    input  logic [PW-1:0]         page_erase,
    input  logic [N_AREAS*PW-1:0] area_first,
    input  logic [N_AREAS*PW-1:0] area_last,
    output logic                  hit_prog,
    output logic                  hit_erase,
    output logic                  any_active
);
    logic [N_AREAS-1:0] act;
    logic [N_AREAS-1:0] in_prog;
    logic [N_AREAS-1:0] in_erase;

    for (genvar g = 0; g < N_AREAS; g++) begin : g_area
        logic [PW-1:0] lo;
        logic [PW-1:0] hi;
        assign lo          = area_first[g*PW +: PW];
        assign hi          = area_last[g*PW +: PW];
        // area is live only with an ordered range
        assign act[g]      = (lo <= hi);
        assign in_prog[g]  = act[g] && (page_prog >= lo) && (page_prog <= hi);
        assign in_erase[g] = act[g] && (page_erase >= lo) && (page_erase <= hi);
    end

    assign hit_prog   = |in_prog;
    assign hit_erase  = |in_erase;
    assign any_active = |act;
endmodule

// File: rtl/qwp_wbuf.sv
// Quad-word write buffer. Gathers word writes into 128-bit storage, tracks
// the word count and the quad-word address taken from the first word.
// Assumes the controller never loads or drops while an operation runs.
module qwp_wbuf
    import qwp_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               load,
    input  logic               drop,
    input  logic               retire,
    input  logic               frozen,
    output logic               pending,
    output logic               last_word,
    output logic               align_ok,
    output logic [AW-5:0]      qaddr,
    output logic [QWORD_W-1:0] qdata,
    output logic [QWORD_W-1:0] merged
);
    localparam int QAW = AW - 4;
    localparam int CW  = $clog2(LANES);

    logic [CW-1:0]      cnt_q;
    logic [QAW-1:0]     qaddr_q;
    logic [QWORD_W-1:0] data_q;
    logic               pend_q;
    logic [CW-1:0]      lane;

    assign lane = wr_addr[3:2];

    // alignment rule for the word being offered now
    always_comb begin
        if (cnt_q == '0) align_ok = (wr_addr[3:0] == 4'h0);
        else             align_ok = (wr_addr[1:0] == 2'b00) && (wr_addr[AW-1:4] == qaddr_q);
    end

    // buffer contents with the offered word placed in its lane
    always_comb begin
        merged = (cnt_q == '0) ? '1 : data_q;
        merged[lane*WORD_W +: WORD_W] = wr_data;
    end

    // storage, count and pending state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            qaddr_q <= '0;
            data_q  <= '1;
            pend_q  <= 1'b0;
        end else if (drop) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= cnt_q + 1'b1;
            data_q <= merged;
            pend_q <= 1'b1;
            if (cnt_q == '0) qaddr_q <= wr_addr[AW-1:4];
        end else if (retire) begin
            pend_q <= 1'b0;
        end
    end

    assign pending   = pend_q;
    assign last_word = (cnt_q == CW'(LANES - 1));
    assign qaddr     = qaddr_q;
    assign qdata     = data_q;

    // R9
    frozen_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(data_q) && $stable(qaddr_q));
endmodule

// File: rtl/qwp_ctrl.sv
// Sequencer control. Judges each bus write and start pulse against the size,
// alignment, blank, protection and sequence rules, launches array commands,
// holds busy until the array's done pulse and keeps the sticky flags.
// Assumes arr_done is a single-cycle pulse given only while a request is high.
module qwp_ctrl
    import qwp_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_en,
    input  logic               perase,
    input  logic               merase,
    input  logic [PW-1:0]      page_sel,
    input  logic               start_set,
    input  logic               eop_ie,
    input  logic               err_ie,
    input  logic               wr_valid,
    input  logic [1:0]         wr_size,
    input  logic [N_FLAGS-1:0] flag_clr,
    input  logic               buf_last,
    input  logic               buf_align_ok,
    input  logic               merged_zero,
    input  logic               arr_blank,
    input  logic               prot_prog_hit,
    input  logic               prot_erase_hit,
    input  logic               prot_any,
    input  logic               arr_done,
    output logic               busy,
    output logic               start_flag,
    output logic [N_FLAGS-1:0] flags,
    output logic               buf_load,
    output logic               buf_drop,
    output logic               buf_retire,
    output op_e                op,
    output logic [PW-1:0]      erase_page,
    output logic               irq_eop,
    output logic               irq_err
);
    logic               busy_q;
    logic               start_q;
    logic [N_FLAGS-1:0] flags_q;
    op_e                op_q;
    op_e                op_n;
    logic [PW-1:0]      page_q;
    logic [PW-1:0]      page_n;
    logic [N_FLAGS-1:0] set_f;
    logic               launch;
    logic               strt;
    logic               finish;

    assign finish = busy_q && arr_done;

    // request judgement and flag-set vector for this cycle
    always_comb begin
        set_f      = '0;
        buf_load   = 1'b0;
        buf_drop   = 1'b0;
        buf_retire = 1'b0;
        launch     = 1'b0;
        strt       = 1'b0;
        op_n       = op_q;
        page_n     = page_q;
        if (!busy_q) begin
            if (start_set) begin
                case ({perase, merase})
                    2'b10: begin
                        if (prot_erase_hit) set_f[F_WRPERR] = 1'b1;
                        else begin
                            launch = 1'b1;
                            strt   = 1'b1;
                            op_n   = OP_EPAGE;
                            page_n = page_sel;
                        end
                    end
                    2'b01: begin
                        if (prot_any) set_f[F_WRPERR] = 1'b1;
                        else begin
                            launch = 1'b1;
                            strt   = 1'b1;
                            op_n   = OP_EALL;
                        end
                    end
                    default: set_f[F_PGSERR] = 1'b1;
                endcase
            end else if (wr_valid && prog_en) begin
                if (wr_size != SZ_WORD) begin
                    set_f[F_SIZERR] = 1'b1;
                    buf_drop        = 1'b1;
                end else if (!buf_align_ok) begin
                    set_f[F_PGAERR] = 1'b1;
                    buf_drop        = 1'b1;
                end else if (!buf_last) begin
                    buf_load = 1'b1;
                end else if (prot_prog_hit) begin
                    set_f[F_WRPERR] = 1'b1;
                    buf_drop        = 1'b1;
                end else if (!arr_blank && !merged_zero) begin
                    set_f[F_PROGERR] = 1'b1;
                    buf_drop         = 1'b1;
                end else begin
                    buf_load = 1'b1;
                    launch   = 1'b1;
                    op_n     = OP_PROG;
                end
            end
        end else if (start_set || wr_valid) begin
            set_f[F_PGSERR] = 1'b1;
        end
        if (err_ie && (|set_f[F_PGSERR:F_PROGERR])) set_f[F_OPERR] = 1'b1;
        if (finish) begin
            if (eop_ie) set_f[F_EOP] = 1'b1;
            buf_retire = (op_q == OP_PROG);
            op_n       = OP_IDLE;
        end
    end

    // operation state: busy, start, opcode and erase page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            op_q    <= OP_IDLE;
            page_q  <= '0;
        end else begin
            busy_q  <= launch | (busy_q & ~arr_done);
            start_q <= strt | (start_q & ~finish);
            op_q    <= op_n;
            page_q  <= page_n;
        end
    end

    // sticky flags: clear by strobe, new events win
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | set_f;
    end

    assign busy       = busy_q;
    assign start_flag = start_q;
    assign flags      = flags_q;
    assign op         = op_q;
    assign erase_page = page_q;
    assign irq_eop    = flags_q[F_EOP] & eop_ie;
    assign irq_err    = flags_q[F_OPERR] & err_ie;

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(arr_done));
    // R8
    start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q);
    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (wr_valid || start_set) |=> flags_q[F_PGSERR] && busy_q);
    // R10
    eop_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[F_EOP]) |-> $past(eop_ie));
endmodule

// File: rtl/qw_prog_seq.sv
// Quad-word flash program sequencer top. Wires the write buffer, the
// protection check and the controller, and drives the array request lines.
// Assumes PAGE_SHIFT >= 4 so a page holds whole quad-words.
module qw_prog_seq
    import qwp_pkg::*;
#(
    parameter int AW         = 20,
    parameter int PAGE_SHIFT = 13,
    parameter int N_AREAS    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_prog,
    input  logic                          ctl_page_erase,
    input  logic                          ctl_mass_erase,
    input  logic [AW-PAGE_SHIFT-1:0]      ctl_page,
    input  logic                          ctl_start,
    input  logic                          ctl_eop_ie,
    input  logic                          ctl_err_ie,
    input  logic                          bus_wr_valid,
    input  logic [AW-1:0]                 bus_wr_addr,
    input  logic [31:0]                   bus_wr_data,
    input  logic [1:0]                    bus_wr_size,
    input  logic [N_AREAS*(AW-PAGE_SHIFT)-1:0] wp_first,
    input  logic [N_AREAS*(AW-PAGE_SHIFT)-1:0] wp_last,
    input  logic [6:0]                    sts_clear,
    output logic [6:0]                    sts_flags,
    output logic                          sts_busy,
    output logic                          sts_pending,
    output logic                          sts_start,
    output logic                          irq_eop,
    output logic                          irq_err,
    output logic                          arr_prog_req,
    output logic                          arr_page_erase_req,
    output logic                          arr_mass_erase_req,
    output logic [AW-5:0]                 arr_qaddr,
    output logic [127:0]                  arr_qdata,
    output logic [AW-PAGE_SHIFT-1:0]      arr_page,
    input  logic                          arr_blank,
    input  logic                          arr_done
);
    localparam int PW  = AW - PAGE_SHIFT;
    localparam int QAW = AW - 4;

    logic               buf_load, buf_drop, buf_retire;
    logic               buf_last, buf_align_ok, buf_pending;
    logic [QAW-1:0]     buf_qaddr;
    logic [QWORD_W-1:0] buf_qdata, buf_merged;
    logic               hit_prog, hit_erase, any_active;
    logic               busy;
    op_e                op;

    qwp_wbuf #(.AW(AW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr   (bus_wr_addr),
        .wr_data   (bus_wr_data),
        .load      (buf_load),
        .drop      (buf_drop),
        .retire    (buf_retire),
        .frozen    (busy),
        .pending   (buf_pending),
        .last_word (buf_last),
        .align_ok  (buf_align_ok),
        .qaddr     (buf_qaddr),
        .qdata     (buf_qdata),
        .merged    (buf_merged)
    );

    qwp_prot_check #(.PW(PW), .N_AREAS(N_AREAS)) u_prot (
        .page_prog  (buf_qaddr[QAW-1 -: PW]),
        .page_erase (ctl_page),
        .area_first (wp_first),
        .area_last  (wp_last),
        .hit_prog   (hit_prog),
        .hit_erase  (hit_erase),
        .any_active (any_active)
    );

    qwp_ctrl #(.PW(PW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_en        (ctl_prog),
        .perase         (ctl_page_erase),
        .merase         (ctl_mass_erase),
        .page_sel       (ctl_page),
        .start_set      (ctl_start),
        .eop_ie         (ctl_eop_ie),
        .err_ie         (ctl_err_ie),
        .wr_valid       (bus_wr_valid),
        .wr_size        (bus_wr_size),
        .flag_clr       (sts_clear),
        .buf_last       (buf_last),
        .buf_align_ok   (buf_align_ok),
        .merged_zero    (buf_merged == '0),
        .arr_blank      (arr_blank),
        .prot_prog_hit  (hit_prog),
        .prot_erase_hit (hit_erase),
        .prot_any       (any_active),
        .arr_done       (arr_done),
        .busy           (busy),
        .start_flag     (sts_start),
        .flags          (sts_flags),
        .buf_load       (buf_load),
        .buf_drop       (buf_drop),
        .buf_retire     (buf_retire),
        .op             (op),
        .erase_page     (arr_page),
        .irq_eop        (irq_eop),
        .irq_err        (irq_err)
    );

    // array request decode from the running operation
    always_comb begin
        arr_prog_req       = busy && (op == OP_PROG);
        arr_page_erase_req = busy && (op == OP_EPAGE);
        arr_mass_erase_req = busy && (op == OP_EALL);
    end

    assign sts_busy    = busy;
    assign sts_pending = buf_pending;
    assign arr_qaddr   = buf_qaddr;
    assign arr_qdata   = buf_qdata;

    // R2
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_prog_req, arr_page_erase_req, arr_mass_erase_req}));
    // R2
    pending_at_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_prog_req |-> sts_pending);
endmodule

// File: tb/test_qw_prog_seq.sv
// Directed bench for qw_prog_seq with a behavioural flash array model.
module test_qw_prog_seq;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_prog = 0, ctl_page_erase = 0, ctl_mass_erase = 0;
    logic [6:0]   ctl_page = '0;
    logic         ctl_start = 0, ctl_eop_ie = 1, ctl_err_ie = 1;
    logic         bus_wr_valid = 0;
    logic [19:0]  bus_wr_addr = '0;
    logic [31:0]  bus_wr_data = '0;
    logic [1:0]   bus_wr_size = 2'd2;
    logic [13:0]  wp_first = {7'd9, 7'd9};
    logic [13:0]  wp_last = {7'd2, 7'd2};
    logic [6:0]   sts_clear = '0;
    logic [6:0]   sts_flags;
    logic         sts_busy, sts_pending, sts_start, irq_eop, irq_err;
    logic         arr_prog_req, arr_page_erase_req, arr_mass_erase_req;
    logic [15:0]  arr_qaddr;
    logic [127:0] arr_qdata;
    logic [6:0]   arr_page;
    logic         arr_blank;
    logic         arr_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    qw_prog_seq i_qw_prog_seq (.*);

    // behavioural flash array: 64 modelled quad-words in page 0
    logic [127:0] mem [0:63];
    int           cnt;
    assign arr_blank = (arr_qaddr < 16'd64) ? (mem[arr_qaddr[5:0]] == '1) : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= 0;
            arr_done <= 1'b0;
            for (int i = 0; i < 64; i++) mem[i] <= '1;
        end else begin
            arr_done <= 1'b0;
            if ((arr_prog_req || arr_page_erase_req || arr_mass_erase_req) && !arr_done) begin
                if (cnt == LAT - 1) begin
                    arr_done <= 1'b1;
                    cnt      <= 0;
                    if (arr_prog_req && arr_qaddr < 16'd64)
                        mem[arr_qaddr[5:0]] <= mem[arr_qaddr[5:0]] & arr_qdata;
                    if (arr_mass_erase_req || (arr_page_erase_req && arr_page == 7'd0))
                        for (int i = 0; i < 64; i++) mem[i] <= '1;
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_wr_valid = 1'b1; bus_wr_addr = a; bus_wr_data = d; bus_wr_size = sz;
        @(negedge clk);
        bus_wr_valid = 1'b0;
    endtask

    task automatic start(input logic pe, input logic me, input logic [6:0] pg);
        ctl_page_erase = pe; ctl_mass_erase = me; ctl_page = pg;
        @(negedge clk);
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
    endtask

    task automatic clr(input logic [6:0] m);
        @(negedge clk);
        sts_clear = m;
        @(negedge clk);
        sts_clear = '0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (sts_busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 flags", sts_flags, 7'h00);
        chk("R1 busy/pending/start", {sts_busy, sts_pending, sts_start}, 3'b000);
        chk("R1 reqs", {arr_prog_req, arr_page_erase_req, arr_mass_erase_req}, 3'b000);
    endtask

    task automatic t_program();
        int n;
        clr(7'h7F); ctl_prog = 1;
        wr(20'h00020, 32'hA0A0_0000, 2'd2);
        chk("R2 pending after first word", {sts_pending, sts_busy}, 2'b10);
        wr(20'h00028, 32'hA2A2_0002, 2'd2);
        wr(20'h00024, 32'hA1A1_0001, 2'd2);
        wr(20'h0002C, 32'hA3A3_0003, 2'd2);
        chk("R2 prog request", {arr_prog_req, sts_busy}, 2'b11);
        chk("R2 qaddr", arr_qaddr, 16'h0002);
        chk("R2 lanes", arr_qdata, {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000});
        wait_idle(n);
        chk("R8 busy cycles", n, LAT + 1);
        chk("R2 pending cleared", sts_pending, 1'b0);
        chk("R10 eop set", {sts_flags, irq_eop}, {7'h01, 1'b1});
    endtask

    task automatic t_prog_off();
        clr(7'h7F); ctl_prog = 0;
        wr(20'h00030, 32'h1234_5678, 2'd2);
        chk("R13 ignored", {sts_flags, sts_pending, sts_busy}, {7'h00, 2'b00});
        ctl_prog = 1;
    endtask

    task automatic t_size();
        clr(7'h7F);
        wr(20'h00040, 32'h1, 2'd2);
        wr(20'h00044, 32'h2, 2'd1);
        chk("R3 half-word", {sts_flags, sts_pending}, {7'h22, 1'b0});
        chk("R11 irq_err", irq_err, 1'b1);
        clr(7'h7F);
        wr(20'h00040, 32'h1, 2'd0);
        chk("R3 byte first", {sts_flags, sts_pending}, {7'h22, 1'b0});
    endtask

    task automatic t_align();
        clr(7'h7F);
        wr(20'h00044, 32'h1, 2'd2);
        chk("R4 first misaligned", {sts_flags, sts_pending}, {7'h12, 1'b0});
        clr(7'h7F);
        wr(20'h00040, 32'h1, 2'd2);
        wr(20'h00054, 32'h2, 2'd2);
        chk("R4 other quad", {sts_flags, sts_pending}, {7'h12, 1'b0});
    endtask

    task automatic t_blank();
        int n;
        clr(7'h7F);
        for (int i = 0; i < 4; i++) wr(20'h00020 + 20'(4 * i), 32'h5, 2'd2);
        chk("R5 non-blank refused", {sts_flags, sts_busy, sts_pending}, {7'h06, 2'b00});
        clr(7'h7F);
        for (int i = 0; i < 4; i++) wr(20'h00020 + 20'(4 * i), 32'h0, 2'd2);
        chk("R5 zeros accepted", sts_busy, 1'b1);
        wait_idle(n);
        chk("R5 zeros done", sts_flags, 7'h01);
    endtask

    task automatic t_protect();
        int n;
        wp_first = {7'd9, 7'd3}; wp_last = {7'd2, 7'd5};
        ctl_prog = 0;
        clr(7'h7F); start(1, 0, 7'd4);
        chk("R6 erase inside", {sts_flags, sts_busy}, {7'h0A, 1'b0});
        clr(7'h7F); start(1, 0, 7'd5);
        chk("R6 erase last page", {sts_flags, sts_busy}, {7'h0A, 1'b0});
        clr(7'h7F); start(1, 0, 7'd2);
        chk("R6 inactive area", {arr_page_erase_req, sts_busy, sts_start, arr_page}, {3'b111, 7'd2});
        wait_idle(n);
        chk("R8 erase busy cycles", n, LAT + 1);
        chk("R8 start cleared", {sts_start, sts_flags}, {1'b0, 7'h01});
        ctl_prog = 1; clr(7'h7F);
        for (int i = 0; i < 4; i++) wr(20'h06000 + 20'(4 * i), 32'h7, 2'd2);
        chk("R6 program protected", {sts_flags, sts_busy, sts_pending}, {7'h0A, 2'b00});
        ctl_prog = 0; clr(7'h7F); start(0, 1, 7'd0);
        chk("R6 mass refused", {sts_flags, sts_busy}, {7'h0A, 1'b0});
        wp_first = {7'd9, 7'd6};
        clr(7'h7F); start(0, 1, 7'd0);
        chk("R6 mass accepted", {arr_mass_erase_req, sts_busy}, 2'b11);
        wait_idle(n);
        chk("R6 mass done", sts_flags, 7'h01);
    endtask

    task automatic t_seq();
        clr(7'h7F); start(0, 0, 7'd0);
        chk("R7 neither", {sts_flags, sts_busy}, {7'h42, 1'b0});
        clr(7'h7F); start(1, 1, 7'd7);
        chk("R7 both", {sts_flags, sts_busy}, {7'h42, 1'b0});
    endtask

    task automatic t_busy_ignore();
        int n;
        clr(7'h7F); start(1, 0, 7'd7);
        ctl_prog = 1;
        wr(20'h00080, 32'h9, 2'd2);
        chk("R9 write while busy", {sts_flags, sts_busy, sts_pending}, {7'h42, 2'b10});
        start(1, 0, 7'd8);
        chk("R9 start while busy", {sts_busy, arr_page}, {1'b1, 7'd7});
        wait_idle(n);
        chk("R9 op completes", {sts_flags, sts_pending}, {7'h43, 1'b0});
        ctl_prog = 0;
    endtask

    task automatic t_eop_off();
        int n;
        ctl_eop_ie = 0; clr(7'h7F); start(1, 0, 7'd7);
        wait_idle(n);
        chk("R10 no eop", {sts_flags, irq_eop}, {7'h00, 1'b0});
        ctl_eop_ie = 1;
    endtask

    task automatic t_err_off();
        ctl_err_ie = 0; clr(7'h7F); start(0, 0, 7'd0);
        chk("R11 no operr", {sts_flags, irq_err}, {7'h40, 1'b0});
        ctl_err_ie = 1;
    endtask

    task automatic t_clear();
        int n;
        clr(7'h7F); start(1, 0, 7'd7);
        wait_idle(n);
        start(0, 0, 7'd0);
        chk("R12 setup", sts_flags, 7'h43);
        clr(7'h40);
        chk("R12 partial clear", sts_flags, 7'h03);
        @(negedge clk);
        ctl_page_erase = 0; ctl_mass_erase = 0;
        ctl_start = 1; sts_clear = 7'h40;
        @(negedge clk);
        ctl_start = 0; sts_clear = '0;
        chk("R12 set wins", sts_flags, 7'h43);
        clr(7'h7F);
        chk("R12 full clear", {sts_flags, irq_eop, irq_err}, {7'h00, 2'b00});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_prog_off();
        t_size();
        t_align();
        t_blank();
        t_protect();
        t_seq();
        t_busy_ignore();
        t_eop_off();
        t_err_off();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule